// File: doc/BRIEF.md
# Hexadecimal Floating-Point Normalizer

This block takes the unnormalized intermediate result of a base-16 floating-point operation and turns it into a packed, normalized word. The input is a sign, a signed exponent that is already biased by 64 but carries extra range, and a fraction of 15 hex digits. In double precision the top 14 digits are the result fraction and the lowest is a guard digit. In single precision only the top 7 digits take part: 6 result digits plus one guard digit. The block shifts the fraction left one hex digit per clock until the leading digit is nonzero, and it lowers the exponent by one for every digit shifted.

Once the fraction is normalized the guard digit is dropped without rounding, and the final exponent is checked against the 7-bit field range 0..127. An exponent that is too high raises the overflow flag and leaves the result register holding its previous word. An exponent that is too low raises the same flag and clears the result to zero. An all-zero fraction gives a true zero with no flag. A one-cycle start pulse launches an operation, busy stays high while it runs, and a one-cycle done pulse marks the cycle in which the result and the flag are updated.

Top module: `hexfp_normalizer`

## Requirements
- R1: While reset is high, and in the first cycle after it, busy, done, ovf and result are all zero.
- R2: start is accepted only while busy is low, and busy is high in the cycle after acceptance. A start pulse given while busy is high has no effect on the operation in progress or on its result.
- R3: The fraction is shifted left by whole 4-bit digits until its top digit is nonzero, and the exponent drops by one per digit. With s leading zero digits in the used part of the fraction, done is high s+1 cycles after the start cycle.
- R4: When dbl=0 only in_frac[59:32] (the top 7 digits) is used, and in_frac[31:0] is ignored. The result is {sign, exponent[6:0], top 6 normalized digits} in result[63:32]. The 7th digit is truncated and result[31:0] is zero.
- R5: When dbl=1 all 15 digits are used. The result is {sign in bit 63, exponent in bits 62:56, top 14 normalized digits in bits 55:0}, and the lowest (guard) digit is truncated.
- R6: A used fraction that is all zero gives a result of all zero bits and ovf=0, with done high one cycle after start.
- R7: A normalized exponent above 127 sets ovf to 1 and leaves result equal to its value before the operation.
- R8: A normalized exponent below 0 sets ovf to 1 and clears result to zero.
- R9: Normalized exponents of exactly 0 and exactly 127 are in range: ovf is 0 and the exponent field holds that value.
- R10: done is a single-cycle pulse, and busy is low in the cycle done is high. result and ovf change only in a done cycle and hold their values until the next one. A new start may be given in the cycle right after done.
- R11: For a nonzero fraction whose exponent is in range, result bit 63 equals the input sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted when idle |
| dbl | input | 1 | 1 selects double precision, 0 selects single |
| in_sign | input | 1 | Sign of the intermediate result |
| in_exp | input | EXP_W (9) | Signed exponent, biased by 64, with extra range |
| in_frac | input | 60 | 15-digit fraction including the guard digit |
| busy | output | 1 | Normalization in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Packed normalized word |
| ovf | output | 1 | Exponent out of range (overflow or underflow) |

## Verification
The assertions check the following on every cycle:
- the one-digit step of fraction and exponent during shifting;
- the single-cycle done pulse and its exclusion with busy;
- result and ovf holding between completions;
- the outcome of each exponent class (kept word on overflow, zero on underflow and on a zero fraction);
- a nonzero leading digit in every in-range result.

Only the bench scenarios can show the following:
- the packed layouts for the two precisions;
- that the low input digits are ignored in single precision;
- the exact latency for a given count of leading zeros;
- the inclusive edges at exponents 0 and 127;
- that a start pulse during busy leaves the running result untouched.

A behavioural reference model predicts all four outputs for each cycle.

// File: rtl/hexfp_pkg.sv
package hexfp_pkg;

    localparam int DIGIT_W     = 4;
    localparam int SGL_DIGITS  = 6;
    localparam int DBL_DIGITS  = 14;
    localparam int FRAC_IN_DIG = DBL_DIGITS + 1;
    localparam int FRAC_IN_W   = FRAC_IN_DIG * DIGIT_W;
    localparam int FRAC_OUT_W  = DBL_DIGITS * DIGIT_W;
    localparam int EXP_FIELD_W = 7;
    localparam int WORD_W      = 1 + EXP_FIELD_W + FRAC_OUT_W;
    localparam int SGL_USED_W  = (SGL_DIGITS + 1) * DIGIT_W;
    localparam int EXP_MAX     = (1 << EXP_FIELD_W) - 1;

    typedef enum logic [1:0] {
        EC_OK,
        EC_ZERO,
        EC_OFLOW,
        EC_UFLOW
    } exp_class_e;

    typedef enum logic {
        ST_IDLE,
        ST_NORM
    } norm_state_e;

    // Keeps only the digits that take part for the selected precision.
    function automatic logic [FRAC_IN_W-1:0] used_digits_mask(input logic dbl);
        logic [FRAC_IN_W-1:0] m;
        m = '1;
        if (!dbl) begin
            m = {{SGL_USED_W{1'b1}}, {(FRAC_IN_W - SGL_USED_W){1'b0}}};
        end
        return m;
    endfunction

endpackage

// File: rtl/hexfp_digit_shifter.sv
module hexfp_digit_shifter
    import hexfp_pkg::*;
#(
    parameter int EXP_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic                    shift,
    input  logic [FRAC_IN_W-1:0]    ld_frac,
    input  logic signed [EXP_W-1:0] ld_exp,
    output logic [FRAC_OUT_W-1:0]   frac_top,
    output logic signed [EXP_W-1:0] exp_q,
    output logic                    lead_zero,
    output logic                    frac_zero
);

    logic [FRAC_IN_W-1:0] frac_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frac_q <= '0;
            exp_q  <= '0;
        end else if (load) begin
            frac_q <= ld_frac;
            exp_q  <= ld_exp;
        end else if (shift) begin
            frac_q <= {frac_q[FRAC_IN_W-DIGIT_W-1:0], {DIGIT_W{1'b0}}};
            exp_q  <= exp_q - 1'b1;
        end
    end

    assign frac_top  = frac_q[FRAC_IN_W-1 -: FRAC_OUT_W];
    assign lead_zero = (frac_q[FRAC_IN_W-1 -: DIGIT_W] == '0);
    assign frac_zero = (frac_q == '0);

    // R3: each shift step lowers the exponent by exactly one
    a_r3_exp_step: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> (exp_q == $past(exp_q) - 1'b1));

    // R3: the second digit moves into the leading position
    a_r3_digit_step: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=>
        (frac_q[FRAC_IN_W-1 -: DIGIT_W] == $past(frac_q[FRAC_IN_W-DIGIT_W-1 -: DIGIT_W])));

endmodule

// File: rtl/hexfp_exp_classify.sv
module hexfp_exp_classify
    import hexfp_pkg::*;
#(
    parameter int EXP_W = 10
) (
    input  logic signed [EXP_W-1:0] exp_in,
    input  logic                    frac_zero,
    output exp_class_e              cls
);

    localparam logic signed [EXP_W-1:0] TOP_EXP = EXP_W'(EXP_MAX);

    always_comb begin
        if (frac_zero) begin
            cls = EC_ZERO;
        end else if (exp_in[EXP_W-1]) begin
            cls = EC_UFLOW;
        end else if (exp_in > TOP_EXP) begin
            cls = EC_OFLOW;
        end else begin
            cls = EC_OK;
        end
    end

endmodule

// File: rtl/hexfp_packer.sv
module hexfp_packer
    import hexfp_pkg::*;
(
    input  logic                   dbl,
    input  logic                   sign,
    input  logic [EXP_FIELD_W-1:0] exp_field,
    input  logic [FRAC_OUT_W-1:0]  frac,
    output logic [WORD_W-1:0]      word
);

    logic [FRAC_OUT_W-1:0] frac_out;

    for (genvar i = 0; i < DBL_DIGITS; i++) begin : g_slot
        if (i < SGL_DIGITS) begin : g_always
            assign frac_out[FRAC_OUT_W-1-i*DIGIT_W -: DIGIT_W] =
                frac[FRAC_OUT_W-1-i*DIGIT_W -: DIGIT_W];
        end else begin : g_dbl_only
            assign frac_out[FRAC_OUT_W-1-i*DIGIT_W -: DIGIT_W] =
                dbl ? frac[FRAC_OUT_W-1-i*DIGIT_W -: DIGIT_W] : '0;
        end
    end

    assign word = {sign, exp_field, frac_out};

endmodule

// File: rtl/hexfp_normalizer.sv
module hexfp_normalizer
    import hexfp_pkg::*;
#(
    parameter int EXP_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    dbl,
    input  logic                    in_sign,
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [FRAC_IN_W-1:0]    in_frac,
    output logic                    busy,
    output logic                    done,
    output logic [WORD_W-1:0]       result,
    output logic                    ovf
);

    localparam int IEXP_W = EXP_W + 1;

    norm_state_e               state_q;
    logic                      dbl_q;
    logic                      sign_q;
    logic [FRAC_OUT_W-1:0]     frac_top;
    logic signed [IEXP_W-1:0]  exp_q;
    logic signed [IEXP_W-1:0]  ld_exp;
    logic [FRAC_IN_W-1:0]      ld_frac;
    logic                      lead_zero;
    logic                      frac_zero;
    logic                      load;
    logic                      shift;
    logic                      fin;
    exp_class_e                cls;
    logic [WORD_W-1:0]         packed_w;

    assign load    = start && (state_q == ST_IDLE);
    assign fin     = (state_q == ST_NORM) && (frac_zero || !lead_zero);
    assign shift   = (state_q == ST_NORM) && !fin;
    assign busy    = (state_q == ST_NORM);
    assign ld_frac = in_frac & used_digits_mask(dbl);
    assign ld_exp  = IEXP_W'(in_exp);

    hexfp_digit_shifter #(.EXP_W(IEXP_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .shift     (shift),
        .ld_frac   (ld_frac),
        .ld_exp    (ld_exp),
        .frac_top  (frac_top),
        .exp_q     (exp_q),
        .lead_zero (lead_zero),
        .frac_zero (frac_zero)
    );

    hexfp_exp_classify #(.EXP_W(IEXP_W)) u_class (
        .exp_in    (exp_q),
        .frac_zero (frac_zero),
        .cls       (cls)
    );

    hexfp_packer u_pack (
        .dbl       (dbl_q),
        .sign      (sign_q),
        .exp_field (exp_q[EXP_FIELD_W-1:0]),
        .frac      (frac_top),
        .word      (packed_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            dbl_q   <= 1'b0;
            sign_q  <= 1'b0;
            done    <= 1'b0;
            result  <= '0;
            ovf     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                state_q <= ST_NORM;
                dbl_q   <= dbl;
                sign_q  <= in_sign;
            end else if (fin) begin
                state_q <= ST_IDLE;
                done    <= 1'b1;
                unique case (cls)
                    EC_ZERO: begin
                        result <= '0;
                        ovf    <= 1'b0;
                    end
                    EC_UFLOW: begin
                        result <= '0;
                        ovf    <= 1'b1;
                    end
                    EC_OFLOW: begin
                        ovf    <= 1'b1;
                    end
                    default: begin
                        result <= packed_w;
                        ovf    <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R2: an accepted start makes the block busy
    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R10: done lasts one cycle and never overlaps busy
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(result) && $stable(ovf)));

    // R7: overflow keeps the previous word and raises the flag
    a_r7_oflow_keep: assert property (@(posedge clk) disable iff (rst)
        (fin && cls == EC_OFLOW) |=> (ovf && $stable(result)));

    // R8: underflow clears the word and raises the flag
    a_r8_uflow_clear: assert property (@(posedge clk) disable iff (rst)
        (fin && cls == EC_UFLOW) |=> (ovf && result == '0));

    // R6: zero fraction gives true zero, no flag
    a_r6_true_zero: assert property (@(posedge clk) disable iff (rst)
        (fin && cls == EC_ZERO) |=> (!ovf && result == '0));

    // R3: an in-range nonzero result has a nonzero leading digit
    a_r3_normalized: assert property (@(posedge clk) disable iff (rst)
        (done && !ovf && result != '0) |->
        (result[FRAC_OUT_W-1 -: DIGIT_W] != '0));

endmodule

// File: tb/hexfp_normalizer_bench.sv
module hexfp_normalizer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        dbl = 1'b0;
    logic        in_sign = 1'b0;
    logic [8:0]  in_exp = '0;
    logic [59:0] in_frac = '0;
    logic        busy, done, ovf;
    logic [63:0] result;

    always #2 clk = ~clk;   // 250 MHz

    hexfp_normalizer u_hexfp_normalizer (
        .clk(clk), .rst(rst), .start(start), .dbl(dbl), .in_sign(in_sign),
        .in_exp(in_exp), .in_frac(in_frac), .busy(busy), .done(done),
        .result(result), .ovf(ovf)
    );

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    string cur_tag = "R1";

    // reference model state
    bit          m_busy = 0, m_done = 0, m_ovf = 0;
    logic [63:0] m_res = '0;
    int          m_cnt = 0;
    bit          p_ovf, p_keep;
    logic [63:0] p_res;

    function automatic void ref_calc(input bit d, input bit s, input logic [8:0] ex,
                                     input logic [59:0] fr, output int lat,
                                     output bit o, output bit keep, output logic [63:0] r);
        int e;
        int lz;
        logic [59:0] f;
        e  = $signed(ex);
        f  = d ? fr : (fr & {28'hFFFFFFF, 32'h0});
        o = 0; keep = 0; r = '0; lz = 0;
        if (f == '0) begin
            lat = 1;
            return;
        end
        while (f[59:56] == 4'h0) begin
            f = f << 4;
            lz++;
        end
        e   = e - lz;
        lat = lz + 1;
        if (e > 127) begin
            o = 1; keep = 1;
        end else if (e < 0) begin
            o = 1;
        end else if (d) begin
            r = {s, 7'(e), f[59:4]};
        end else begin
            r = {s, 7'(e), f[59:36], 32'h0};
        end
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_busy = 0; m_done = 0; m_ovf = 0; m_res = '0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (m_cnt == 1) begin
                    m_busy = 0; m_done = 1; m_ovf = p_ovf;
                    if (!p_keep) m_res = p_res;
                end else begin
                    m_cnt--;
                end
            end else if (start) begin
                ref_calc(dbl, in_sign, in_exp, in_frac, m_cnt, p_ovf, p_keep, p_res);
                m_busy = 1;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (cyc > 0) begin
            total++;
            if (busy !== m_busy || done !== m_done || ovf !== m_ovf || result !== m_res) begin
                bad++;
                $display("FAIL %s cyc=%0d actual busy=%b done=%b ovf=%b res=%h expected busy=%b done=%b ovf=%b res=%h",
                         cur_tag, cyc, busy, done, ovf, result, m_busy, m_done, m_ovf, m_res);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic issue(input bit d, input bit s, input int e, input logic [59:0] f,
                         input string tag, input bit overlap);
        @(negedge clk);
        cur_tag = tag;
        dbl = d; in_sign = s; in_exp = e[8:0]; in_frac = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (overlap) begin
            // R2: second start during busy must be ignored
            dbl = 1'b1; in_sign = 1'b0; in_exp = 9'd10; in_frac = 60'hFFFFFFFFFFFFFFF;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (m_busy || busy) @(negedge clk);
    endtask

    initial begin
        logic [31:0] lcg;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        issue(1, 0, 65,  60'hF23456789ABCDE1, "R5", 0);
        issue(1, 1, 70,  60'h000123456789ABC, "R3", 0);
        issue(1, 0, 80,  60'h000000000000007, "R3", 0);
        issue(0, 0, 66,  60'h00ABCDEFFFFFFFF, "R4", 0);
        issue(0, 1, 64,  60'h000000912345678, "R4", 0);
        issue(1, 1, 50,  60'h000000000000000, "R6", 0);
        issue(0, 0, 50,  60'h0000000FFFFFFFF, "R6", 0);
        issue(1, 0, 127, 60'h100000000000000, "R9", 0);
        issue(1, 0, 130, 60'h100000000000000, "R7", 0);
        issue(1, 0, 3,   60'h000500000000000, "R9", 0);
        issue(1, 0, 2,   60'h000500000000000, "R8", 0);
        issue(0, 0, -5,  60'h800000000000000, "R8", 0);
        issue(1, 1, 90,  60'h0A0000000000001, "R11", 0);
        issue(0, 0, 200, 60'h010000000000000, "R7", 0);
        issue(1, 0, 70,  60'h000123456789ABC, "R2", 1);
        issue(0, 1, 64,  60'h123456700000000, "R10", 0);
        issue(1, 0, 64,  60'h00000ABCDEF0123, "R10", 0);
        lcg = 32'h1234_5677;
        for (int k = 0; k < 40; k++) begin
            logic [59:0] f;
            int sh;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            f   = {lcg, lcg[27:0]};
            sh  = int'(lcg[31:28]);
            f   = f >> (4 * sh);
            issue(lcg[0], lcg[1], int'(lcg[10:4]) - 10, f, "R3", 0);
        end
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule